// File: doc/BRIEF.md
# Level-Priority Interrupt Acknowledge Resolver

This block collects interrupt requests as sticky pending bits and arbitrates among them on a grid of seven levels, each with nine priority slots. Each populated grid cell is fed by one pending source or by a software force bit, and carries its own 7-bit vector number. Cells without a feed are tied inactive.

Two read-only acknowledge ports give vector numbers back to the processor. The global port returns the single most urgent pending request anywhere on the grid. The per-level port returns the most urgent request inside one level, chosen by a 3-bit index. Each port loads its result on its own read strobe and holds it until that strobe comes again. A read never clears a request. The block also drives the highest level that has something pending, so an interrupt-mask comparator can use it directly.

Slot numbering inside a level follows urgency. Slot 8 is priority 7, slots 7, 6 and 5 are priorities 6, 5 and 4, slot 4 is the midpoint, and slots 3 down to 0 are priorities 3 down to 0.

Top module: `irq_lvlpri_resolver`

## Requirements
- R1: The cell at level L (1..7) and slot S (0..8) has index C = (L-1)*9 + S and vector 64 + C. Slots 1, 3, 4, 5 and 7 of every level are fed by sources, in that order, by source index (L-1)*5 + 0..4. Slot 6 of levels 4..7 is fed by force bit L-4. Every other cell never requests.
- R2: After a global read, glb_ack holds the vector of the pending cell with the highest level. Among cells on that level, the cell with the highest slot wins.
- R3: A global read taken while nothing is pending loads glb_ack with 0.
- R4: After a per-level read with rd_lvl_sel = n (1..7), lvl_ack holds the vector of the highest pending slot in level n. If level n has nothing pending, or if n is 0, lvl_ack holds 24.
- R5: Bit 7 of glb_ack and bit 7 of lvl_ack is always 0.
- R6: Each acknowledge register loads on the clock edge where its read strobe is high. The value it loads reflects the pending state as it was before that edge. It keeps its value on every edge without its strobe.
- R7: src_set[i] makes source i pending from the next edge on. src_clr[i] clears it. When both are high together, set wins. A read does not change pending state.
- R8: On an edge where force_wr is high, the four force bits load from force_wdata. Writing 0 to a force bit withdraws its request.
- R9: top_level gives the highest level with a pending cell, or 0 when no cell is pending. It follows the pending state without an extra register stage.
- R10: Reset clears all pending and force bits and sets both acknowledge outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_set | input | 35 | Per-source set strobes |
| src_clr | input | 35 | Per-source clear strobes |
| force_wr | input | 1 | Load strobe for the force bits |
| force_wdata | input | 4 | Force bits; bit k feeds level 4+k |
| rd_glb | input | 1 | Global acknowledge read strobe |
| rd_lvl | input | 1 | Per-level acknowledge read strobe |
| rd_lvl_sel | input | 3 | Level chosen for the per-level read |
| glb_ack | output | 8 | Global acknowledge vector |
| lvl_ack | output | 8 | Per-level acknowledge vector |
| top_level | output | 3 | Highest pending level, 0 when idle |

## Verification
A set, clear or force strobe changes pending state at the edge that samples it. top_level shows that change in the same cycle after the edge. An acknowledge appears one edge after its read strobe and reflects the pending state from before that edge. The bench therefore drives inputs on the falling edge. It checks top_level at the next falling edge after a strobe, and checks an acknowledge at the falling edge after its read. One directed case asserts a set and a read together to confirm the read sees the old state. Another changes pending state with no read to confirm the acknowledge holds.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
    localparam int LVLS         = 7;
    localparam int SLOTS        = 9;
    localparam int CELLS        = LVLS * SLOTS;
    localparam int VEC_W        = 7;
    localparam int ACK_W        = VEC_W + 1;
    localparam int LVL_W        = 3;
    localparam int MID_SLOT     = 4;
    localparam int FORCE_SLOT   = 6;
    localparam int FORCE_LO_LVL = 4;
    localparam int NFORCE       = LVLS - FORCE_LO_LVL + 1;
    localparam int SRC_PER_LVL  = 5;
    localparam int NSRC         = LVLS * SRC_PER_LVL;
    localparam int VEC_BASE     = 64;
    localparam int SPUR_VEC     = 24;

    // rank of a source-fed slot inside its level, -1 when the slot has no source
    function automatic int slot_src_rank(input int s);
        case (s)
            1:       return 0;
            3:       return 1;
            MID_SLOT: return 2;
            5:       return 3;
            7:       return 4;
            default: return -1;
        endcase
    endfunction

    function automatic int cell_src(input int lvl, input int s);
        int r;
        r = slot_src_rank(s);
        return (r < 0) ? -1 : (lvl - 1) * SRC_PER_LVL + r;
    endfunction

    function automatic bit cell_forced(input int lvl, input int s);
        return (lvl >= FORCE_LO_LVL) && (s == FORCE_SLOT);
    endfunction

    function automatic logic [VEC_W-1:0] cell_vec(input int lvl, input int s);
        int v;
        v = VEC_BASE + (lvl - 1) * SLOTS + s;
        return v[VEC_W-1:0];
    endfunction

    typedef struct packed {
        logic [NSRC-1:0]   pend;
        logic [NFORCE-1:0] frc;
    } pend_state_t;

    typedef struct packed {
        logic [ACK_W-1:0] glb;
        logic [ACK_W-1:0] lvl;
    } ack_regs_t;
endpackage

// File: rtl/irq_pend_store.sv
module irq_pend_store
    import irq_res_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_set,
    input  logic [NSRC-1:0]   src_clr,
    input  logic              force_wr,
    input  logic [NFORCE-1:0] force_wdata,
    output logic [NSRC-1:0]   pend_o,
    output logic [NFORCE-1:0] frc_o
);
    pend_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~src_clr) | src_set;
        if (force_wr) begin
            st_d.frc = force_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign frc_o  = st_q.frc;

    p_set_sticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set != '0) |=> ((st_q.pend & $past(src_set)) == $past(src_set)));

    p_clr_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_clr & ~src_set) != '0) |=> ((st_q.pend & $past(src_clr & ~src_set)) == '0));

    p_force_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        force_wr |=> (st_q.frc == $past(force_wdata)));

    p_force_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !force_wr |=> $stable(st_q.frc));
endmodule

// File: rtl/irq_grid_map.sv
module irq_grid_map
    import irq_res_pkg::*;
(
    input  logic [NSRC-1:0]               pend_i,
    input  logic [NFORCE-1:0]             frc_i,
    output logic [LVLS-1:0][SLOTS-1:0]    cell_req_o
);
    for (genvar l = 0; l < LVLS; l++) begin : g_lvl
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            localparam int SI = cell_src(l + 1, s);
            if (cell_forced(l + 1, s)) begin : g_force
                assign cell_req_o[l][s] = frc_i[l + 1 - FORCE_LO_LVL];
            end else if (SI >= 0) begin : g_src
                assign cell_req_o[l][s] = pend_i[SI];
            end else begin : g_empty
                assign cell_req_o[l][s] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb
    import irq_res_pkg::*;
#(
    parameter int LVL = 1
) (
    input  logic [SLOTS-1:0] req_i,
    output logic             any_o,
    output logic [VEC_W-1:0] vec_o
);
    // scan upward so the highest pending slot is the last to write
    always_comb begin
        any_o = 1'b0;
        vec_o = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (req_i[s]) begin
                any_o = 1'b1;
                vec_o = cell_vec(LVL, s);
            end
        end
    end

    always_comb begin
        if (any_o) begin
            a_vec_in_level_r1: assert (int'(vec_o) >= VEC_BASE + (LVL - 1) * SLOTS &&
                                       int'(vec_o) <  VEC_BASE + LVL * SLOTS);
        end
    end
endmodule

// File: rtl/irq_lvlpri_resolver.sv
module irq_lvlpri_resolver
    import irq_res_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_set,
    input  logic [NSRC-1:0]   src_clr,
    input  logic              force_wr,
    input  logic [NFORCE-1:0] force_wdata,
    input  logic              rd_glb,
    input  logic              rd_lvl,
    input  logic [LVL_W-1:0]  rd_lvl_sel,
    output logic [ACK_W-1:0]  glb_ack,
    output logic [ACK_W-1:0]  lvl_ack,
    output logic [LVL_W-1:0]  top_level
);
    logic [NSRC-1:0]            pend_w;
    logic [NFORCE-1:0]          frc_w;
    logic [LVLS-1:0][SLOTS-1:0] cell_req_w;
    logic [LVLS-1:0]            lvl_any_w;
    logic [LVLS-1:0][VEC_W-1:0] lvl_vec_w;

    irq_pend_store u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_set     (src_set),
        .src_clr     (src_clr),
        .force_wr    (force_wr),
        .force_wdata (force_wdata),
        .pend_o      (pend_w),
        .frc_o       (frc_w)
    );

    irq_grid_map u_map (
        .pend_i     (pend_w),
        .frc_i      (frc_w),
        .cell_req_o (cell_req_w)
    );

    for (genvar l = 0; l < LVLS; l++) begin : g_arb
        irq_level_arb #(.LVL(l + 1)) u_arb (
            .req_i (cell_req_w[l]),
            .any_o (lvl_any_w[l]),
            .vec_o (lvl_vec_w[l])
        );
    end

    logic [VEC_W-1:0] glb_vec;
    logic [LVL_W-1:0] top_lvl;
    logic [VEC_W-1:0] sel_vec;
    ack_regs_t        ack_d, ack_q;

    // global winner: upward scan lets the highest level overwrite
    always_comb begin
        glb_vec = '0;
        top_lvl = '0;
        for (int l = 0; l < LVLS; l++) begin
            if (lvl_any_w[l]) begin
                glb_vec = lvl_vec_w[l];
                top_lvl = LVL_W'(l + 1);
            end
        end
    end

    always_comb begin
        int idx;
        idx     = int'(rd_lvl_sel);
        sel_vec = VEC_W'(SPUR_VEC);
        for (int l = 0; l < LVLS; l++) begin
            if (idx == l + 1 && lvl_any_w[l]) begin
                sel_vec = lvl_vec_w[l];
            end
        end
    end

    always_comb begin
        ack_d = ack_q;
        if (rd_glb) begin
            ack_d.glb = {1'b0, glb_vec};
        end
        if (rd_lvl) begin
            ack_d.lvl = {1'b0, sel_vec};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q <= '0;
        end else begin
            ack_q <= ack_d;
        end
    end

    assign glb_ack   = ack_q.glb;
    assign lvl_ack   = ack_q.lvl;
    assign top_level = top_lvl;

    p_rsvd_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_ack[ACK_W-1] == 1'b0) && (lvl_ack[ACK_W-1] == 1'b0));

    p_glb_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_glb |=> $stable(glb_ack));

    p_lvl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_lvl |=> $stable(lvl_ack));

    p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_glb && top_level == '0) |=> (glb_ack == '0));

    p_busy_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_glb && top_level != '0) |=> (int'(glb_ack) >= VEC_BASE));

    p_sel_zero_spur_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lvl && rd_lvl_sel == '0) |=> (int'(lvl_ack) == SPUR_VEC));

    p_top_matches_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_glb && top_level != '0) |=>
            ((int'(glb_ack) - VEC_BASE) / SLOTS == int'($past(top_level)) - 1));
endmodule

// File: tb/irq_lvlpri_resolver_test.sv
module irq_lvlpri_resolver_test;
    import irq_res_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   src_set = '0;
    logic [NSRC-1:0]   src_clr = '0;
    logic              force_wr = 1'b0;
    logic [NFORCE-1:0] force_wdata = '0;
    logic              rd_glb = 1'b0;
    logic              rd_lvl = 1'b0;
    logic [LVL_W-1:0]  rd_lvl_sel = '0;
    logic [ACK_W-1:0]  glb_ack, lvl_ack;
    logic [LVL_W-1:0]  top_level;

    irq_lvlpri_resolver uut (.*);

    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    logic [NSRC-1:0]   m_pend = '0;
    logic [NFORCE-1:0] m_frc = '0;

    // bench view of the grid (R1)
    function automatic bit b_cell_on(input int l, input int s);
        int base;
        base = (l - 1) * 5;
        if (l >= 4 && s == 6) return m_frc[l - 4];
        case (s)
            1: return m_pend[base];
            3: return m_pend[base + 1];
            4: return m_pend[base + 2];
            5: return m_pend[base + 3];
            7: return m_pend[base + 4];
            default: return 1'b0;
        endcase
    endfunction

    function automatic int exp_glb();
        for (int l = 7; l >= 1; l--)
            for (int s = 8; s >= 0; s--)
                if (b_cell_on(l, s)) return 64 + (l - 1) * 9 + s;
        return 0;
    endfunction

    function automatic int exp_lvl(input int n);
        if (n < 1 || n > 7) return 24;
        for (int s = 8; s >= 0; s--)
            if (b_cell_on(n, s)) return 64 + (n - 1) * 9 + s;
        return 24;
    endfunction

    function automatic int exp_top();
        for (int l = 7; l >= 1; l--)
            for (int s = 0; s < 9; s++)
                if (b_cell_on(l, s)) return l;
        return 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one edge of set/clear/force; ends on a falling edge
    task automatic step(input logic [NSRC-1:0] s, input logic [NSRC-1:0] c,
                        input logic fw, input logic [NFORCE-1:0] fd);
        src_set = s; src_clr = c; force_wr = fw; force_wdata = fd;
        @(posedge clk);
        m_pend = (m_pend & ~c) | s;
        if (fw) m_frc = fd;
        @(negedge clk);
        src_set = '0; src_clr = '0; force_wr = 1'b0;
    endtask

    task automatic read_both(input int sel, input string req);
        int eg, el;
        eg = exp_glb();
        el = exp_lvl(sel);
        rd_glb = 1'b1; rd_lvl = 1'b1; rd_lvl_sel = LVL_W'(sel);
        @(posedge clk);
        @(negedge clk);
        rd_glb = 1'b0; rd_lvl = 1'b0;
        chk({req, " glb"}, int'(glb_ack), eg);
        chk({req, " lvl"}, int'(lvl_ack), el);
        chk("R5 rsvd", int'(glb_ack[7]) + int'(lvl_ack[7]), 0);
    endtask

    function automatic logic [NSRC-1:0] src_bit(input int i);
        logic [NSRC-1:0] v;
        v = '0;
        v[i] = 1'b1;
        return v;
    endfunction

    initial begin
        #(10 * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h1c0de5));
        @(negedge clk); @(negedge clk);
        chk("R10 glb reset", int'(glb_ack), 0);
        chk("R10 lvl reset", int'(lvl_ack), 0);
        chk("R10 top reset", int'(top_level), 0);
        rst_n = 1'b1;
        @(negedge clk);

        read_both(3, "R3/R4 empty grid");

        // source 0 -> level 1 slot 1 -> vector 65
        step(src_bit(0), '0, 1'b0, '0);
        chk("R9 top lvl1", int'(top_level), 1);
        read_both(1, "R1/R2 single src0");
        chk("R1 vec 65", int'(glb_ack), 65);
        read_both(2, "R4 empty level2");
        chk("R4 spurious", int'(lvl_ack), 24);
        read_both(0, "R4 sel zero");

        // midpoint (src 12) beats priority 3 (src 11) in level 3 -> 86
        step(src_bit(11) | src_bit(12), '0, 1'b0, '0);
        read_both(3, "R2 midpoint over p3");
        chk("R2 midpoint vec", int'(lvl_ack), 86);
        step('0, src_bit(12), 1'b0, '0);
        read_both(3, "R2 p3 after mid clear");

        // force level 7 -> slot 6 -> 124
        step('0, '0, 1'b1, 4'b1000);
        chk("R9 top force7", int'(top_level), 7);
        read_both(7, "R8 force7");
        chk("R8 force vec", int'(glb_ack), 124);
        step('0, '0, 1'b1, 4'b0000);
        read_both(7, "R8 force cleared");

        // set and clear together: set wins
        step(src_bit(34), src_bit(34), 1'b0, '0);
        read_both(7, "R7 set wins");
        // read does not clear
        read_both(7, "R7 read keeps");

        // read together with a set sees the old state
        begin
            int eg;
            eg = exp_glb();
            src_set = src_bit(33); rd_glb = 1'b1;
            @(posedge clk);
            m_pend = m_pend | src_bit(33);
            @(negedge clk);
            src_set = '0; rd_glb = 1'b0;
            chk("R6 read before set", int'(glb_ack), eg);
        end

        // hold without a read
        begin
            int held_g, held_l;
            held_g = int'(glb_ack); held_l = int'(lvl_ack);
            step('1, '0, 1'b1, 4'b1111);
            @(negedge clk);
            chk("R6 glb hold", int'(glb_ack), held_g);
            chk("R6 lvl hold", int'(lvl_ack), held_l);
        end

        // clear everything: empty grid
        step('0, '1, 1'b1, '0);
        chk("R9 top idle", int'(top_level), 0);
        read_both(5, "R3 cleared grid");

        // random mix
        for (int it = 0; it < 400; it++) begin
            logic [63:0] a, b, c;
            logic [NSRC-1:0] sv, cv;
            a = {$urandom(), $urandom()};
            b = {$urandom(), $urandom()};
            c = {$urandom(), $urandom()};
            sv = a[NSRC-1:0] & b[NSRC-1:0] & c[NSRC-1:0];
            cv = a[NSRC-1:0] ^ b[NSRC-1:0];
            if (it % 50 == 49) begin
                step('0, '1, 1'b1, '0);
            end else begin
                step(sv, cv, ($urandom() % 4) == 0, NFORCE'($urandom()));
            end
            chk("R9 top rand", int'(top_level), exp_top());
            read_both(int'($urandom() % 8), "R2/R4 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule